// File: doc/BRIEF.md
# Pixel Format Converter with Color Lookup Table

This block takes a stream of 32-bit memory words and turns it into a stream of ARGB8888 pixels. One input format is selected at a time from eleven codes. Five are direct formats: ARGB8888, RGB888, RGB565, ARGB1555 and ARGB4444. Four are indexed through a local color lookup table: L8, L4, AL44 and AL88. Two carry alpha only: A8 and A4. Words that hold several pixels are unpacked one pixel per cycle, lowest bits first. RGB888 pixels may straddle word boundaries. After decoding, the alpha channel is passed through, replaced or scaled by a constant, according to the selected alpha mode.

Both the input and the output use a valid/ready handshake. The lookup table is loaded through a write port while the stream is idle. A write issued while pixels are in flight is dropped and reported on an error pulse. The surrounding fetch engine changes the format, alpha mode and constants only while the block is idle.

Top module: `pix_fmt_cvt`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o is 0, clut_err_o is 0 and in_ready_o is 1.
- R2: With mode_i=0000 (ARGB8888) each word is one pixel, passed through unchanged. With mode_i=0001 (RGB888) pixels are 3 bytes, taken from the byte stream lowest byte first. A pixel may span two words, so three words yield four pixels. The output alpha is 0xFF.
- R3: Modes 0010 (RGB565, R[15:11] G[10:5] B[4:0]), 0011 (ARGB1555, A[15] R[14:10] G[9:5] B[4:0]) and 0100 (ARGB4444, A[15:12] R[11:8] G[7:4] B[3:0]) take two pixels per word, with the low halfword first. A channel narrower than 8 bits is widened by copying its top bits into the freed low bits. The 1-bit alpha becomes 0x00 or 0xFF. RGB565 gives alpha 0xFF.
- R4: Mode 0101 (L8) takes four byte indices per word, low byte first. Mode 1000 (L4) takes eight nibble indices, low nibble first, and addresses table entries 0 to 15 directly. The output is the whole 32-bit table entry, stored as A[31:24] R[23:16] G[15:8] B[7:0].
- R5: Mode 0110 (AL44) takes four bytes per word, each with alpha in [7:4] and index in [3:0]. The table address is the index copied into both nibbles, so index 2 reads entry 0x22. The output alpha is the widened pixel alpha, and the RGB comes from the entry.
- R6: Mode 0111 (AL88) takes two halfwords per word, each with alpha in [15:8] and index in [7:0]. The output alpha is the pixel alpha, and the RGB comes from the entry.
- R7: Mode 1001 (A8, four bytes per word) and mode 1010 (A4, eight nibbles per word) take the pixel alpha from the data, widened for A4. The RGB comes from const_rgb_i.
- R8: The alpha mode sets the output alpha. amode_i=00 keeps the decoded alpha. 01 replaces it with const_alpha_i. 10 gives round(alpha*const_alpha_i/255). 11 behaves as 00.
- R9: A table write is taken only when the block is idle. The block is busy when in_valid_i is high, a partly used word is buffered, or an output pixel is pending. A write made while busy leaves the entry unchanged and raises clut_err_o for exactly the following cycle.
- R10: While out_valid_o is high and out_ready_i is low, out_pix_o holds its value. No pixel is lost or repeated under back-pressure. With one pixel per word and out_ready_i held high, N words are delivered within N+2 cycles.
- R11: The reserved mode codes 1011 to 1111 behave as ARGB8888.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted this cycle when valid |
| in_word_i | input | 32 | Packed pixel data |
| mode_i | input | 4 | Input format code |
| amode_i | input | 2 | Alpha mode |
| const_alpha_i | input | 8 | Constant alpha for replace and scale |
| const_rgb_i | input | 24 | RGB used by the alpha-only formats |
| clut_we_i | input | 1 | Table write strobe |
| clut_addr_i | input | 8 | Table write address |
| clut_wdata_i | input | 32 | Table write data, ARGB |
| clut_err_o | output | 1 | Pulse: a table write was rejected |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Output pixel accepted |
| out_pix_o | output | 32 | ARGB8888 pixel |

## Verification
The riskiest internal state is the nibble count of the unpack buffer. If it is wrong by even one nibble, every following pixel is misaligned and the output channels look swapped or shifted. This shows on the very next compared pixel and stays wrong until reset. A stale or wrongly written table entry shows only when that index is streamed, so the tests stream the specific entries they touched. A wrong busy decision shows within one cycle as a missing or spurious error pulse.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 32;

  localparam logic [3:0] FMT_ARGB8888 = 4'd0;
  localparam logic [3:0] FMT_RGB888   = 4'd1;
  localparam logic [3:0] FMT_RGB565   = 4'd2;
  localparam logic [3:0] FMT_ARGB1555 = 4'd3;
  localparam logic [3:0] FMT_ARGB4444 = 4'd4;
  localparam logic [3:0] FMT_L8       = 4'd5;
  localparam logic [3:0] FMT_AL44     = 4'd6;
  localparam logic [3:0] FMT_AL88     = 4'd7;
  localparam logic [3:0] FMT_L4       = 4'd8;
  localparam logic [3:0] FMT_A8       = 4'd9;
  localparam logic [3:0] FMT_A4       = 4'd10;

  typedef enum logic [1:0] {
    AM_KEEP  = 2'd0,
    AM_FIXED = 2'd1,
    AM_SCALE = 2'd2,
    AM_RSVD  = 2'd3
  } amode_e;

  // pixel size in nibbles
  function automatic logic [3:0] fmt_nibbles(input logic [3:0] f);
    case (f)
      FMT_RGB888:                                   return 4'd6;
      FMT_RGB565, FMT_ARGB1555, FMT_ARGB4444,
      FMT_AL88:                                     return 4'd4;
      FMT_L8, FMT_AL44, FMT_A8:                     return 4'd2;
      FMT_L4, FMT_A4:                               return 4'd1;
      default:                                      return 4'd8;
    endcase
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pfc_unpack.sv
module pfc_unpack #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic [3:0]        need_i,
  output logic              pix_valid_o,
  input  logic              pix_take_i,
  output logic [WORD_W-1:0] pix_raw_o,
  output logic              busy_o
);
  localparam int NIB_W = WORD_W / 4;
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(2 * NIB_W + 1);

  logic [BUF_W-1:0] pbuf_q, pbuf_d, shifted, ins;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_rem, need_w;
  logic             take, acc;

  assign need_w      = CNT_W'(need_i);
  assign pix_valid_o = (cnt_q >= need_w) && (need_w != '0);
  assign take        = pix_valid_o & pix_take_i;
  assign cnt_rem     = take ? (cnt_q - need_w) : cnt_q;
  // room for one more word once this cycle's pixel leaves
  assign in_ready_o  = (cnt_rem <= CNT_W'(NIB_W));
  assign acc         = in_valid_i & in_ready_o;

  assign shifted = take ? (pbuf_q >> {need_w, 2'b00}) : pbuf_q;
  assign ins     = {{(BUF_W-WORD_W){1'b0}}, in_word_i} << {cnt_rem, 2'b00};
  assign pbuf_d  = acc ? (shifted | ins) : shifted;
  assign cnt_d   = acc ? (cnt_rem + CNT_W'(NIB_W)) : cnt_rem;

  assign pix_raw_o = pbuf_q[WORD_W-1:0];
  assign busy_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pbuf_q <= '0;
      cnt_q  <= '0;
    end else begin
      pbuf_q <= pbuf_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pfc_clut.sv
module pfc_clut #(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 32,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pfc_expand.sv
module pfc_expand
  import pfc_pkg::*;
(
  input  logic [3:0]       fmt_i,
  input  logic [WORD_W-1:0] raw_i,
  input  logic [PIX_W-1:0] clut_i,
  input  logic [23:0]      const_rgb_i,
  output logic [7:0]       idx_o,
  output logic [PIX_W-1:0] argb_o
);
  always_comb begin
    case (fmt_i)
      FMT_L4:   idx_o = {4'h0, raw_i[3:0]};
      FMT_AL44: idx_o = {raw_i[3:0], raw_i[3:0]};
      default:  idx_o = raw_i[7:0];
    endcase
  end

  always_comb begin
    case (fmt_i)
      FMT_RGB888:   argb_o = {8'hFF, raw_i[23:0]};
      FMT_RGB565:   argb_o = {8'hFF, widen5(raw_i[15:11]), widen6(raw_i[10:5]),
                              widen5(raw_i[4:0])};
      FMT_ARGB1555: argb_o = {{8{raw_i[15]}}, widen5(raw_i[14:10]),
                              widen5(raw_i[9:5]), widen5(raw_i[4:0])};
      FMT_ARGB4444: argb_o = {widen4(raw_i[15:12]), widen4(raw_i[11:8]),
                              widen4(raw_i[7:4]), widen4(raw_i[3:0])};
      FMT_L8, FMT_L4: argb_o = clut_i;
      FMT_AL44:     argb_o = {widen4(raw_i[7:4]), clut_i[23:0]};
      FMT_AL88:     argb_o = {raw_i[15:8], clut_i[23:0]};
      FMT_A8:       argb_o = {raw_i[7:0], const_rgb_i};
      FMT_A4:       argb_o = {widen4(raw_i[3:0]), const_rgb_i};
      default:      argb_o = raw_i;
    endcase
  end
endmodule

// File: rtl/pfc_alpha.sv
module pfc_alpha
  import pfc_pkg::*;
#(
  parameter bit ROUND = 1'b1
) (
  input  logic [PIX_W-1:0] argb_i,
  input  logic [1:0]       amode_i,
  input  logic [7:0]       const_alpha_i,
  output logic [PIX_W-1:0] argb_o
);
  logic [15:0] prod;
  logic [7:0]  mul_a;

  assign prod = 16'(argb_i[31:24]) * 16'(const_alpha_i);

  generate
    if (ROUND) begin : g_round
      logic [15:0] t;
      assign t     = prod + 16'd128;
      assign mul_a = 8'((t + (t >> 8)) >> 8); // exact round(a*c/255)
    end else begin : g_trunc
      assign mul_a = prod[15:8];
    end
  endgenerate

  always_comb begin
    argb_o = argb_i;
    case (amode_e'(amode_i))
      AM_FIXED: argb_o[31:24] = const_alpha_i;
      AM_SCALE: argb_o[31:24] = mul_a;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pix_fmt_cvt.sv
module pix_fmt_cvt
  import pfc_pkg::*;
#(
  parameter int CLUT_ENTRIES = 256,
  parameter bit MUL_ROUND    = 1'b1,
  localparam int CLUT_AW     = $clog2(CLUT_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [WORD_W-1:0]  in_word_i,
  input  logic [3:0]         mode_i,
  input  logic [1:0]         amode_i,
  input  logic [7:0]         const_alpha_i,
  input  logic [23:0]        const_rgb_i,
  input  logic               clut_we_i,
  input  logic [CLUT_AW-1:0] clut_addr_i,
  input  logic [PIX_W-1:0]   clut_wdata_i,
  output logic               clut_err_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [PIX_W-1:0]   out_pix_o
);
  logic              pix_valid, stage_free, load, busy, active;
  logic [WORD_W-1:0] pix_raw;
  logic [7:0]        clut_idx;
  logic [PIX_W-1:0]  clut_rdata, argb_dec, argb_mod;
  logic              out_valid_q, clut_err_q;
  logic [PIX_W-1:0]  out_pix_q;

  assign stage_free = ~out_valid_q | out_ready_i;
  assign load       = pix_valid & stage_free;
  assign active     = in_valid_i | busy | out_valid_q;

  pfc_unpack #(.WORD_W(WORD_W)) i_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_word_i  (in_word_i),
    .need_i     (fmt_nibbles(mode_i)),
    .pix_valid_o(pix_valid),
    .pix_take_i (stage_free),
    .pix_raw_o  (pix_raw),
    .busy_o     (busy)
  );

  pfc_clut #(.ENTRIES(CLUT_ENTRIES), .DATA_W(PIX_W)) i_clut (
    .clk_i  (clk_i),
    .we_i   (clut_we_i & ~active),
    .waddr_i(clut_addr_i),
    .wdata_i(clut_wdata_i),
    .raddr_i(clut_idx[CLUT_AW-1:0]),
    .rdata_o(clut_rdata)
  );

  pfc_expand i_expand (
    .fmt_i      (mode_i),
    .raw_i      (pix_raw),
    .clut_i     (clut_rdata),
    .const_rgb_i(const_rgb_i),
    .idx_o      (clut_idx),
    .argb_o     (argb_dec)
  );

  pfc_alpha #(.ROUND(MUL_ROUND)) i_alpha (
    .argb_i       (argb_dec),
    .amode_i      (amode_i),
    .const_alpha_i(const_alpha_i),
    .argb_o       (argb_mod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_pix_q   <= '0;
      clut_err_q  <= 1'b0;
    end else begin
      clut_err_q <= clut_we_i & active;
      if (load) begin
        out_valid_q <= 1'b1;
        out_pix_q   <= argb_mod;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_pix_o   = out_pix_q;
  assign clut_err_o  = clut_err_q;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [3:0]  mode_i,
  input logic [1:0]  amode_i,
  input logic [7:0]  const_alpha_i,
  input logic        clut_we_i,
  input logic        clut_err_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_pix_o
);
  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o));

  a_r9_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clut_we_i && (in_valid_i || out_valid_o) |=> clut_err_o);

  a_r9_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clut_err_o |-> $past(clut_we_i));

  a_r8_fixed_alpha: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && amode_i == 2'd1 && $past(amode_i) == 2'd1 && $stable(const_alpha_i)
    |-> out_pix_o[31:24] == const_alpha_i);

  a_r2_opaque_rgb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && mode_i == 4'd1 && $past(mode_i) == 4'd1 &&
    amode_i == 2'd0 && $past(amode_i) == 2'd0
    |-> out_pix_o[31:24] == 8'hFF);
endmodule

bind pix_fmt_cvt pfc_checker i_pfc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .mode_i       (mode_i),
  .amode_i      (amode_i),
  .const_alpha_i(const_alpha_i),
  .clut_we_i    (clut_we_i),
  .clut_err_o   (clut_err_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_pix_o    (out_pix_o)
);

// File: tb/test_pix_fmt_cvt.sv
module test_pix_fmt_cvt;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        in_valid_i;
  logic        in_ready_o;
  logic [31:0] in_word_i;
  logic [3:0]  mode_i;
  logic [1:0]  amode_i;
  logic [7:0]  const_alpha_i;
  logic [23:0] const_rgb_i;
  logic        clut_we_i;
  logic [7:0]  clut_addr_i;
  logic [31:0] clut_wdata_i;
  logic        clut_err_o;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [31:0] out_pix_o;

  pix_fmt_cvt i_pix_fmt_cvt (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  logic [31:0] wq[$];
  logic [31:0] eq[$];
  logic [31:0] tb_clut [256];
  logic [63:0] pk = '0;
  int          pk_n = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] w4(input logic [3:0] v); return {v, v}; endfunction
  function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] v); return {v, v[5:4]}; endfunction

  function automatic logic [7:0] ea(input logic [7:0] a);
    case (amode_i)
      2'd1:    return const_alpha_i;
      2'd2:    return 8'((2 * int'(a) * int'(const_alpha_i) + 255) / 510);
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] ent(input int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h5A, b, 8'(i * 3), ~b};
  endfunction

  // append one pixel of nb bits to the word stream and its expected output
  task automatic put(input logic [31:0] v, input int nb, input logic [31:0] argb);
    logic [63:0] m = (64'd1 << nb) - 64'd1;
    pk = pk | ((({32'd0, v}) & m) << pk_n);
    pk_n += nb;
    if (pk_n >= 32) begin
      wq.push_back(pk[31:0]);
      pk = pk >> 32;
      pk_n -= 32;
    end
    eq.push_back({ea(argb[31:24]), argb[23:0]});
  endtask

  task automatic run_stream(input string req, input bit stall, output int iters);
    int n = 0;
    while ((wq.size() != 0 || eq.size() != 0) && n < 2000) begin
      @(negedge clk_i);
      in_valid_i  = (wq.size() != 0);
      in_word_i   = (wq.size() != 0) ? wq[0] : 32'd0;
      out_ready_i = stall ? ((n % 3) != 1) : 1'b1;
      #(CLK_P/4);
      if (out_valid_o && out_ready_i) begin
        if (eq.size() != 0) chk(req, out_pix_o, eq.pop_front());
        else chk({req, " extra pixel"}, out_pix_o, 32'hxxxx_xxxx);
      end
      if (in_valid_i && in_ready_o) void'(wq.pop_front());
      n++;
    end
    @(negedge clk_i);
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    if (n >= 2000) chk({req, " stream hung"}, 32'd0, 32'd1);
    iters = n;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; in_valid_i = 0; in_word_i = 0; mode_i = 0; amode_i = 0;
    const_alpha_i = 8'hFF; const_rgb_i = 24'h123456; clut_we_i = 0;
    clut_addr_i = 0; clut_wdata_i = 0; out_ready_i = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 valid in reset", {31'd0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 valid", {31'd0, out_valid_o}, 32'd0);
    chk("R1 err", {31'd0, clut_err_o}, 32'd0);
    chk("R1 ready", {31'd0, in_ready_o}, 32'd1);
  endtask

  task automatic t_argb8888;
    int it;
    mode_i = 4'd0;
    for (int i = 0; i < 8; i++) put(32'h1020_3040 * (i + 1) + i, 32, 32'h1020_3040 * (i + 1) + i);
    run_stream("R2 argb8888", 1'b0, it);
    chk("R10 throughput cycles", it, (it <= 10) ? it : 10);
  endtask

  task automatic t_rgb888;
    int it;
    logic [23:0] p [8] = '{24'hA1B2C3, 24'h0F1E2D, 24'hFFFFFF, 24'h000001,
                          24'h808080, 24'h123456, 24'hFEDCBA, 24'h00FF00};
    mode_i = 4'd1;
    for (int i = 0; i < 8; i++) put({8'h00, p[i]}, 24, {8'hFF, p[i]});
    run_stream("R2 R10 rgb888 straddle/backpressure", 1'b1, it);
  endtask

  task automatic t_16bit;
    int it;
    mode_i = 4'd2;
    put(32'hFFFF, 16, 32'hFFFFFFFF);
    put(32'h0000, 16, 32'hFF000000);
    put(32'hF800, 16, 32'hFFFF0000);
    put(32'h8410, 16, {8'hFF, w5(5'h10), w6(6'h20), w5(5'h10)});
    run_stream("R3 rgb565", 1'b0, it);
    mode_i = 4'd3;
    put(32'h8000, 16, 32'hFF000000);
    put(32'h7FFF, 16, 32'h00FFFFFF);
    put(32'h8421, 16, {8'hFF, w5(5'h01), w5(5'h01), w5(5'h01)});
    put(32'h5555, 16, {8'h00, w5(5'h15), w5(5'h0A), w5(5'h15)});
    run_stream("R3 argb1555", 1'b1, it);
    mode_i = 4'd4;
    put(32'h1234, 16, 32'h11223344);
    put(32'hF0A5, 16, 32'hFF00AA55);
    run_stream("R3 argb4444", 1'b0, it);
  endtask

  task automatic t_clut_load;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      clut_we_i = 1; clut_addr_i = 8'(i); clut_wdata_i = ent(i);
      tb_clut[i] = ent(i);
    end
    @(negedge clk_i);
    clut_we_i = 0;
    chk("R9 idle load no error", {31'd0, clut_err_o}, 32'd0);
  endtask

  task automatic t_l8_l4;
    int it;
    mode_i = 4'd5;
    put(32'h00, 8, tb_clut[8'h00]);
    put(32'h01, 8, tb_clut[8'h01]);
    put(32'h7F, 8, tb_clut[8'h7F]);
    put(32'hFF, 8, tb_clut[8'hFF]);
    run_stream("R4 l8", 1'b0, it);
    mode_i = 4'd8;
    for (int i = 0; i < 16; i++) put(32'(i), 4, tb_clut[i]);
    run_stream("R4 l4", 1'b1, it);
  endtask

  task automatic t_al44;
    int it;
    logic [3:0] a [4] = '{4'h3, 4'hF, 4'h0, 4'h8};
    logic [3:0] l [4] = '{4'h1, 4'h2, 4'hF, 4'h0};
    mode_i = 4'd6;
    for (int i = 0; i < 4; i++)
      put({24'd0, a[i], l[i]}, 8, {w4(a[i]), tb_clut[{l[i], l[i]}][23:0]});
    run_stream("R5 al44", 1'b0, it);
  endtask

  task automatic t_al88;
    int it;
    mode_i = 4'd7;
    put(32'h8022, 16, {8'h80, tb_clut[8'h22][23:0]});
    put(32'h00FF, 16, {8'h00, tb_clut[8'hFF][23:0]});
    run_stream("R6 al88", 1'b0, it);
  endtask

  task automatic t_alpha_only;
    int it;
    logic [3:0] n4 [8] = '{4'hF, 4'h0, 4'h8, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5};
    const_rgb_i = 24'h123456;
    mode_i = 4'd9;
    put(32'h00, 8, 32'h00123456);
    put(32'h7F, 8, 32'h7F123456);
    put(32'hFF, 8, 32'hFF123456);
    put(32'h3C, 8, 32'h3C123456);
    run_stream("R7 a8", 1'b0, it);
    const_rgb_i = 24'hA0B0C0;
    mode_i = 4'd10;
    for (int i = 0; i < 8; i++) put({28'd0, n4[i]}, 4, {w4(n4[i]), 24'hA0B0C0});
    run_stream("R7 a4", 1'b1, it);
  endtask

  task automatic put_amode_set;
    put(32'hFF112233, 32, 32'hFF112233);
    put(32'h80445566, 32, 32'h80445566);
    put(32'h00778899, 32, 32'h00778899);
    put(32'h01AABBCC, 32, 32'h01AABBCC);
  endtask

  task automatic t_amodes;
    int it;
    mode_i = 4'd0;
    amode_i = 2'd1; const_alpha_i = 8'h40;
    put_amode_set();
    run_stream("R8 fixed alpha", 1'b0, it);
    amode_i = 2'd2; const_alpha_i = 8'h80;
    put_amode_set();
    run_stream("R8 scaled alpha 0x80", 1'b0, it);
    chk("R8 scale model 0x80*0x80", {24'd0, ea(8'h80)}, 32'h40);
    const_alpha_i = 8'hFF;
    put_amode_set();
    run_stream("R8 scaled alpha 0xFF", 1'b1, it);
    amode_i = 2'd3; const_alpha_i = 8'h10;
    put_amode_set();
    run_stream("R8 reserved keeps", 1'b0, it);
    amode_i = 2'd0; const_alpha_i = 8'hFF;
  endtask

  task automatic t_clut_guard;
    int it;
    mode_i = 4'd5;
    @(negedge clk_i);
    out_ready_i = 0; in_valid_i = 1; in_word_i = 32'h05050505;
    clut_we_i = 1; clut_addr_i = 8'h05; clut_wdata_i = 32'hDEADBEEF;
    @(negedge clk_i);
    in_valid_i = 0;
    #1;
    chk("R9 reject while input valid", {31'd0, clut_err_o}, 32'd1);
    @(negedge clk_i);
    #1;
    chk("R9 reject while buffered", {31'd0, clut_err_o}, 32'd1);
    clut_we_i = 0;
    @(negedge clk_i);
    #1;
    chk("R9 error is one pulse", {31'd0, clut_err_o}, 32'd0);
    for (int i = 0; i < 4; i++) eq.push_back(tb_clut[5]);
    run_stream("R9 entry unchanged", 1'b0, it);
    @(negedge clk_i);
    clut_we_i = 1; clut_addr_i = 8'h06; clut_wdata_i = 32'hCAFEF00D;
    tb_clut[6] = 32'hCAFEF00D;
    @(negedge clk_i);
    clut_we_i = 0;
    #1;
    chk("R9 idle write no error", {31'd0, clut_err_o}, 32'd0);
    put(32'h06, 8, tb_clut[6]);
    put(32'h06, 8, tb_clut[6]);
    put(32'h05, 8, tb_clut[5]);
    put(32'h06, 8, tb_clut[6]);
    run_stream("R9 idle write taken", 1'b0, it);
  endtask

  task automatic t_reserved;
    int it;
    mode_i = 4'hC;
    put(32'h12345678, 32, 32'h12345678);
    put(32'h00FF00FF, 32, 32'h00FF00FF);
    run_stream("R11 mode 1100", 1'b0, it);
    mode_i = 4'hF;
    put(32'h9ABCDEF0, 32, 32'h9ABCDEF0);
    run_stream("R11 mode 1111", 1'b1, it);
    mode_i = 4'd0;
  endtask

  initial begin
    t_reset();
    t_argb8888();
    t_rgb888();
    t_16bit();
    t_clut_load();
    t_l8_l4();
    t_al44();
    t_al88();
    t_alpha_only();
    t_amodes();
    t_clut_guard();
    t_reserved();
    repeat (3) @(posedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule